// File: doc/BRIEF.md
# Platform-level interrupt controller

This block gathers level-sensitive interrupt requests from a parameterised set of sources and delivers them to a small number of target contexts, each with one interrupt output line. Source identifiers run from 1 to `NUM_SRC`. Identifier 0 is reserved: it is never pending, and a claim value of 0 means that nothing is available.

Each source has a priority register and a gateway that holds one pending bit. Each context has an enable bit for every source, a priority threshold, and a claim/complete register. A source is eligible for a context when it is pending, enabled for that context, and its priority is strictly above that context's threshold. A context's line is high while at least one of its sources is eligible.

Software reads the claim register to take the best eligible source for that context. The read clears the source's pending bit and closes its gateway. Software writes the same identifier back to reopen the gateway. All state is reached through one single-cycle register port, and read data follows the address in the same cycle.

Top module: `irq_router_top`

## Requirements
- R1: After reset every priority, enable bit and threshold reads 0, no source is pending, every `ctx_irq` bit is low and every claim register reads 0.
- R2: The priority of source id is at byte address 4*id and holds `PRIO_W` bits; the bits above them read 0. Address 0 (id 0) always reads 0 and ignores writes.
- R3: The enable word w of context c is at byte address 0x2080 + c*0x100 + 4*w. Source id is bit (id mod 32) of word id/32. Bit 0 of word 0 (id 0) always reads 0.
- R4: The threshold of context c is at 0x201000 + c*0x2000 and holds `PRIO_W` bits. The claim/complete register of context c is at 0x201000 + c*0x2000 + 4.
- R5: A source is eligible for context c only when it is pending, enabled in c, and its priority is strictly greater than c's threshold. Priority 0 is never eligible, and with `PRIO_W`=3 a threshold of 7 blocks the context.
- R6: A high source level sampled at a clock edge makes the source pending after that edge. `ctx_irq[c]` follows eligibility combinationally, with no further delay.
- R7: A claim read (`reg_re` high, `reg_we` low) returns the eligible source with the highest priority, ties going to the lowest id, or 0 when none is eligible.
- R8: A claim clears that source's pending bit at the same edge as the read. No new request from the source is accepted while it is held, even with its level still high.
- R9: Writing id to context c's claim/complete register, with id enabled in c, reopens the gateway. A still-high level makes the source pending again one edge later.
- R10: A completion write whose id is not enabled in the addressed context is ignored, and the gateway stays closed.
- R11: Unmapped, reserved and misaligned (address bits [1:0] not 0) addresses read 0, and writes to them change nothing.
- R12: Pending state is shared by all contexts: a source claimed through one context is no longer eligible in any other context until it is completed and requested again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | NUM_SRC | Level requests, bit k is source id k+1 |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, takes effect at the clock edge |
| reg_re | input | 1 | Read strobe, needed for the claim side effect |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ctx_irq | output | NUM_CTX | Interrupt line per context |

## Verification
A wrong pending or held bit in a gateway shows on `ctx_irq` within the cycle after the edge that corrupted it. It also shows on the next claim read as a wrong identifier. A broken selector, whether on the strict threshold compare or on the tie order, gives a wrong claim value on the first read that meets the case. That is why the bench drains whole sets of sources and compares every claim against an arithmetic model. A decoding slip appears as a wrong readback at a neighbouring or reserved address, so the bench sweeps every priority register and probes reserved words. It also checks a misaligned alias of a live register.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam logic [31:0] EN_BASE    = 32'h0000_2080;
  localparam logic [31:0] EN_STRIDE  = 32'h0000_0100;
  localparam logic [31:0] CTX_BASE   = 32'h0020_1000;
  localparam logic [31:0] CTX_STRIDE = 32'h0000_2000;
  localparam logic [31:0] THR_OFF    = 32'h0;
  localparam logic [31:0] CLAIM_OFF  = 32'h4;

  typedef enum logic [2:0] {
    REG_NONE,
    REG_PRIO,
    REG_EN,
    REG_THR,
    REG_CLAIM
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e   kind;
    logic [7:0]  ctx;
    logic [15:0] idx;
  } reg_hit_t;

  // Map a byte address to a register kind, a context and an index.
  function automatic reg_hit_t decode_addr(logic [31:0] a, int unsigned nsrc,
                                           int unsigned nctx, int unsigned nwords);
    reg_hit_t    hit;
    logic [31:0] off;
    logic [31:0] q;
    logic [31:0] r;
    hit.kind = REG_NONE;
    hit.ctx  = '0;
    hit.idx  = '0;
    if (a[1:0] == 2'b00) begin
      if (a < 32'(4 * (nsrc + 1))) begin
        q        = a >> 2;
        hit.kind = REG_PRIO;
        hit.idx  = q[15:0];
      end else if (a >= EN_BASE && a < EN_BASE + 32'(nctx) * EN_STRIDE) begin
        off = a - EN_BASE;
        q   = off / EN_STRIDE;
        r   = (off % EN_STRIDE) >> 2;
        if (r < 32'(nwords)) begin
          hit.kind = REG_EN;
          hit.ctx  = q[7:0];
          hit.idx  = r[15:0];
        end
      end else if (a >= CTX_BASE && a < CTX_BASE + 32'(nctx) * CTX_STRIDE) begin
        off = a - CTX_BASE;
        q   = off / CTX_STRIDE;
        r   = off % CTX_STRIDE;
        hit.ctx = q[7:0];
        if (r == THR_OFF)        hit.kind = REG_THR;
        else if (r == CLAIM_OFF) hit.kind = REG_CLAIM;
      end
    end
    return hit;
  endfunction

endpackage

// File: rtl/irq_gateway.sv
module irq_gateway (
  input  logic clk,
  input  logic rst_n,
  input  logic src_i,
  input  logic claim_i,
  input  logic complete_i,
  output logic pending_o,
  output logic in_service_o
);

  logic open_req;
  assign open_req = src_i && !pending_o && !in_service_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_o    <= 1'b0;
      in_service_o <= 1'b0;
    end else if (claim_i) begin
      pending_o    <= 1'b0;
      in_service_o <= 1'b1;
    end else begin
      if (open_req)   pending_o    <= 1'b1;
      if (complete_i) in_service_o <= 1'b0;
    end
  end

  AST_CLAIM_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    claim_i |-> pending_o); // R7
  AST_CLAIM_CLOSES_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    claim_i |=> (!pending_o && in_service_o)); // R8
  AST_GATE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_service_o && !pending_o && !complete_i) |=> !pending_o); // R8
  AST_COMPLETE_REOPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (complete_i && !claim_i) |=> !in_service_o); // R9

endmodule

// File: rtl/irq_ctx_select.sv
module irq_ctx_select #(
  parameter int NUM_SRC = 31,
  parameter int PRIO_W  = 3,
  localparam int ID_W   = $clog2(NUM_SRC + 1)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_SRC:1]               pending_i,
  input  logic [NUM_SRC:1]               enable_i,
  input  logic [NUM_SRC:1][PRIO_W-1:0]   prio_i,
  input  logic [PRIO_W-1:0]              thr_i,
  output logic                           irq_o,
  output logic [ID_W-1:0]                best_id_o
);

  // Strict compare: equal to the threshold is not enough.
  function automatic logic above_thr(logic [PRIO_W-1:0] p, logic [PRIO_W-1:0] t);
    return p > t;
  endfunction

  logic [NUM_SRC:1]  elig;
  logic [PRIO_W-1:0] best_p;

  always_comb begin
    for (int i = 1; i <= NUM_SRC; i++)
      elig[i] = pending_i[i] && enable_i[i] && above_thr(prio_i[i], thr_i);
  end

  // Linear scan; strict greater keeps the lowest id on ties.
  always_comb begin
    best_id_o = '0;
    best_p    = '0;
    for (int i = 1; i <= NUM_SRC; i++) begin
      if (elig[i] && prio_i[i] > best_p) begin
        best_id_o = ID_W'(i);
        best_p    = prio_i[i];
      end
    end
  end

  assign irq_o = |elig;

  AST_IRQ_MATCHES_ID: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (best_id_o != '0)); // R6
  AST_BEST_IS_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (best_id_o != '0) |-> (pending_i[best_id_o] && enable_i[best_id_o])); // R7
  AST_MAX_THR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (&thr_i) |-> !irq_o); // R5

endmodule

// File: rtl/irq_router_top.sv
module irq_router_top
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC  = 31,
  parameter int NUM_CTX  = 2,
  parameter int PRIO_W   = 3,
  parameter int ADDR_W   = 24,
  localparam int NUM_WORDS = (NUM_SRC + 1 + 31) / 32,
  localparam int ID_W      = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  input  logic               reg_we,
  input  logic               reg_re,
  output logic [31:0]        reg_rdata,
  output logic [NUM_CTX-1:0] ctx_irq
);

  reg_hit_t hit;
  assign hit = decode_addr({{(32-ADDR_W){1'b0}}, reg_addr}, NUM_SRC, NUM_CTX, NUM_WORDS);

  logic [NUM_SRC:1][PRIO_W-1:0]  prio_q;
  logic [NUM_CTX-1:0][NUM_SRC:1] en_q;
  logic [NUM_CTX-1:0][PRIO_W-1:0] thr_q;
  logic [NUM_SRC:1] pend, insvc, src_claim, src_cpl;
  logic [NUM_CTX-1:0][ID_W-1:0] best_id;
  logic [NUM_CTX-1:0] claim_fire;

  // Named access events.
  logic wr_prio, wr_en, wr_thr, wr_cpl, rd_claim;
  assign wr_prio  = reg_we && hit.kind == REG_PRIO;
  assign wr_en    = reg_we && hit.kind == REG_EN;
  assign wr_thr   = reg_we && hit.kind == REG_THR;
  assign wr_cpl   = reg_we && hit.kind == REG_CLAIM;
  assign rd_claim = reg_re && !reg_we && hit.kind == REG_CLAIM;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio_q <= '0;
    end else if (wr_prio) begin
      for (int i = 1; i <= NUM_SRC; i++)
        if (hit.idx == 16'(i)) prio_q[i] <= reg_wdata[PRIO_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (wr_en) begin
      for (int c = 0; c < NUM_CTX; c++)
        for (int i = 1; i <= NUM_SRC; i++)
          if (hit.ctx == 8'(c) && hit.idx == 16'(i / 32))
            en_q[c][i] <= reg_wdata[i % 32];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q <= '0;
    end else if (wr_thr) begin
      for (int c = 0; c < NUM_CTX; c++)
        if (hit.ctx == 8'(c)) thr_q[c] <= reg_wdata[PRIO_W-1:0];
    end
  end

  // Route claims and completions from contexts to sources.
  always_comb begin
    src_claim = '0;
    src_cpl   = '0;
    for (int c = 0; c < NUM_CTX; c++) begin
      for (int i = 1; i <= NUM_SRC; i++) begin
        if (claim_fire[c] && best_id[c] == ID_W'(i)) src_claim[i] = 1'b1;
        if (wr_cpl && hit.ctx == 8'(c) && reg_wdata == 32'(i) && en_q[c][i])
          src_cpl[i] = 1'b1;
      end
    end
  end

  for (genvar g = 1; g <= NUM_SRC; g++) begin : g_gw
    irq_gateway gw_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .src_i        (irq_src[g-1]),
      .claim_i      (src_claim[g]),
      .complete_i   (src_cpl[g]),
      .pending_o    (pend[g]),
      .in_service_o (insvc[g])
    );
  end

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    irq_ctx_select #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) sel_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .pending_i (pend),
      .enable_i  (en_q[c]),
      .prio_i    (prio_q),
      .thr_i     (thr_q[c]),
      .irq_o     (ctx_irq[c]),
      .best_id_o (best_id[c])
    );
    assign claim_fire[c] = rd_claim && hit.ctx == 8'(c) && best_id[c] != '0;
  end

  always_comb begin
    reg_rdata = '0;
    case (hit.kind)
      REG_PRIO:
        for (int i = 1; i <= NUM_SRC; i++)
          if (hit.idx == 16'(i)) reg_rdata[PRIO_W-1:0] = prio_q[i];
      REG_EN:
        for (int c = 0; c < NUM_CTX; c++)
          for (int i = 1; i <= NUM_SRC; i++)
            if (hit.ctx == 8'(c) && hit.idx == 16'(i / 32)) reg_rdata[i % 32] = en_q[c][i];
      REG_THR:
        for (int c = 0; c < NUM_CTX; c++)
          if (hit.ctx == 8'(c)) reg_rdata[PRIO_W-1:0] = thr_q[c];
      REG_CLAIM:
        for (int c = 0; c < NUM_CTX; c++)
          if (hit.ctx == 8'(c)) reg_rdata[ID_W-1:0] = best_id[c];
      default: reg_rdata = '0;
    endcase
  end

  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_re && hit.kind == REG_NONE) |-> reg_rdata == '0); // R11
  AST_UNMAPPED_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && hit.kind == REG_NONE) |=> ($stable(prio_q) && $stable(en_q) && $stable(thr_q))); // R11
  AST_ONE_CLAIM_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_claim)); // R12
  AST_HELD_NOT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(insvc & pend))); // R8

endmodule

// File: tb/irq_router_top_tb_top.sv
module irq_router_top_tb_top;
  localparam int NS = 31;
  localparam int NC = 2;
  localparam int AW = 24;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic [NS-1:0] src;
  logic [AW-1:0] addr;
  logic [31:0]   wdata, rdata;
  logic          we, re;
  logic [NC-1:0] irq;

  irq_router_top #(.NUM_SRC(NS), .NUM_CTX(NC), .PRIO_W(3), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_src(src), .reg_addr(addr), .reg_wdata(wdata),
    .reg_we(we), .reg_re(re), .reg_rdata(rdata), .ctx_irq(irq));

  int errors = 0;
  int checks = 0;

  int m_prio [1:NS];
  bit m_en   [0:NC-1][1:NS];
  int m_thr  [0:NC-1];
  bit m_pend [1:NS];
  bit m_ins  [1:NS];
  bit op_claim, op_cpl;
  int op_claim_id, op_cpl_id, op_cpl_ctx;

  function automatic logic [AW-1:0] a_prio(int id); return AW'(4 * id); endfunction
  function automatic logic [AW-1:0] a_en(int c, int w); return AW'(32'h2080 + c * 256 + 4 * w); endfunction
  function automatic logic [AW-1:0] a_thr(int c); return AW'(32'h201000 + c * 32'h2000); endfunction
  function automatic logic [AW-1:0] a_clm(int c); return AW'(32'h201004 + c * 32'h2000); endfunction

  function automatic int best(int c);
    int b = 0;
    int bp = 0;
    for (int id = 1; id <= NS; id++)
      if (m_pend[id] && m_en[c][id] && m_prio[id] > m_thr[c] && m_prio[id] > bp) begin
        b = id;
        bp = m_prio[id];
      end
    return b;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    for (int id = 1; id <= NS; id++) begin
      if (op_claim && op_claim_id == id) begin
        m_pend[id] = 0;
        m_ins[id] = 1;
      end else if (src[id-1] && !m_pend[id] && !m_ins[id]) m_pend[id] = 1;
    end
    if (op_cpl && op_cpl_id >= 1 && op_cpl_id <= NS)
      if (m_en[op_cpl_ctx][op_cpl_id]) m_ins[op_cpl_id] = 0;
    @(negedge clk);
    we = 0; re = 0; op_claim = 0; op_cpl = 0;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    addr = a; wdata = d; we = 1;
    step();
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    addr = a; re = 1;
    #1 d = rdata;
    step();
  endtask

  task automatic set_prio(int id, int v);
    wr(a_prio(id), 32'(v));
    m_prio[id] = v % 8;
  endtask

  task automatic set_en(int c, logic [31:0] w);
    wr(a_en(c, 0), w);
    for (int id = 1; id <= NS; id++) m_en[c][id] = w[id];
  endtask

  task automatic set_thr(int c, int v);
    wr(a_thr(c), 32'(v));
    m_thr[c] = v % 8;
  endtask

  task automatic claim(int c, string tag, output int got);
    int e;
    e = best(c);
    addr = a_clm(c); re = 1;
    #1 got = int'(rdata);
    chk(tag, got, e);
    op_claim = (e != 0); op_claim_id = e;
    step();
  endtask

  task automatic complete(int c, int id);
    addr = a_clm(c); wdata = 32'(id); we = 1;
    op_cpl = 1; op_cpl_id = id; op_cpl_ctx = c;
    step();
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int got;
    rst_n = 0; src = '0; addr = '0; wdata = '0; we = 0; re = 0;
    op_claim = 0; op_cpl = 0; op_claim_id = 0; op_cpl_id = 0; op_cpl_ctx = 0;
    for (int id = 1; id <= NS; id++) begin
      m_prio[id] = 0; m_pend[id] = 0; m_ins[id] = 0;
      for (int c = 0; c < NC; c++) m_en[c][id] = 0;
    end
    for (int c = 0; c < NC; c++) m_thr[c] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 ctx_irq", irq, 0);
    rd(a_prio(1), d);   chk("R1 prio1", d, 0);
    rd(a_en(1, 0), d);  chk("R1 enable ctx1", d, 0);
    rd(a_thr(1), d);    chk("R1 thr ctx1", d, 0);
    claim(0, "R1 claim ctx0", got);

    // R2 priority sweep, upper bits dropped, id 0 fixed at 0
    for (int id = 0; id <= NS; id++) begin
      wr(a_prio(id), 32'hA5A5_A5A0 | 32'((id * 3) % 8));
      if (id > 0) m_prio[id] = (id * 3) % 8;
    end
    for (int id = 0; id <= NS; id++) begin
      rd(a_prio(id), d);
      chk($sformatf("R2 prio id %0d", id), d, (id == 0) ? 0 : (id * 3) % 8);
    end

    // R3 enable words
    set_en(0, 32'hFFFF_FFFF);
    set_en(1, 32'h5555_5555);
    rd(a_en(0, 0), d); chk("R3 enable ctx0", d, 32'hFFFF_FFFE);
    rd(a_en(1, 0), d); chk("R3 enable ctx1", d, 32'h5555_5554);

    // R4 thresholds
    set_thr(0, 32'hFF);
    set_thr(1, 3);
    rd(a_thr(0), d); chk("R4 thr ctx0", d, 7);
    rd(a_thr(1), d); chk("R4 thr ctx1", d, 3);

    // R11 reserved, unmapped and misaligned accesses
    wr(24'h84, 32'h7);          rd(24'h84, d);            chk("R11 gap read", d, 0);
    wr(24'h5, 32'h2);           rd(a_prio(1), d);         chk("R11 misaligned write", d, m_prio[1]);
    wr(a_en(0, 1), 32'hFFFF);   rd(a_en(0, 1), d);        chk("R11 enable word 1", d, 0);
    wr(a_thr(0) + 8, 32'h5);    rd(a_thr(0) + 8, d);      chk("R11 ctx reserved", d, 0);
    rd(a_thr(0), d);            chk("R11 thr unchanged", d, m_thr[0]);
    rd(a_thr(2), d);            chk("R11 absent ctx", d, 0);

    // R6 pending timing, then R5 threshold x priority sweep
    set_en(0, 32'h0);
    set_en(1, 32'h0);
    set_en(0, 32'h1 << 5);
    set_prio(5, 4);
    set_thr(0, 0);
    src[4] = 1'b1;
    #1 chk("R6 not yet pending", irq[0], 0);
    step();
    chk("R6 pending raises irq", irq[0], 1);
    for (int p = 0; p < 8; p++)
      for (int t = 0; t < 8; t++) begin
        set_prio(5, p);
        set_thr(0, t);
        chk($sformatf("R5 prio %0d thr %0d", p, t), irq[0], (p > t) ? 1 : 0);
      end
    chk("R5 not enabled ctx1", irq[1], 0);

    // R7 arbitration drain
    set_thr(0, 0);
    for (int id = 1; id <= NS; id++) set_prio(id, (id * 5 + 1) % 8);
    set_en(0, 32'hFFFF_FFFE);
    src = '1;
    step();
    chk("R6 irq with eligible set", irq[0], (best(0) != 0) ? 1 : 0);
    for (int k = 0; k < 40; k++) begin
      int e;
      e = best(0);
      claim(0, "R7 drain claim", got);
      if (k == 0) chk("R7 highest prio lowest id", got, 6);
      if (e == 0) break;
    end

    // R8 gateways held while levels stay high
    step(); step(); step();
    chk("R8 irq low while held", irq[0], 0);
    claim(0, "R8 claim while held", got);
    chk("R8 claim value", got, 0);

    // R12 shared pending state
    set_en(1, 32'hFFFF_FFFE);
    set_thr(1, 0);
    chk("R12 other ctx sees nothing", irq[1], 0);
    set_en(1, 32'h0);

    // R10 completion not enabled in addressed context
    complete(1, 2);
    step(); step();
    chk("R10 irq stays low", irq[0], 0);
    claim(0, "R10 claim after ignored completion", got);

    // R9 completion reopens, level still high
    complete(0, 2);
    step();
    chk("R9 irq after completion", irq[0], 1);
    claim(0, "R9 reclaim", got);
    chk("R9 reclaimed id", got, 2);

    // R9 completion with level dropped
    src[3] = 1'b0;
    complete(0, 4);
    step(); step();
    chk("R9 dropped level no irq", irq[0], 0);
    claim(0, "R9 dropped level claim", got);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule